// File: doc/BRIEF.md
# SPI Slave Pause Controller

This block lets an SPI master pause a transfer that is in progress without releasing the slave's select line. A low-active pause pin is sampled together with the serial clock and chip select. A pause takes effect, or ends, only while the serial clock is low. A pause request that arrives while the clock is high waits for the next low phase. While paused, the output pin is released to high impedance and serial clock edges are ignored. The bit position and the shift register keep their values, so the byte carries on from the same bit once the pause ends.

The block oversamples the three pins with a fast system clock through two-stage synchronizers. It contains the slave's output shifter, which sends bytes MSB first. A transfer works in both clock-idle-low and clock-idle-high SPI timing. Bytes come from the slave core over a valid/ready stream. The block raises `tx_ready` only at a byte boundary, while selected and not paused. The source may hold `tx_valid` low to apply back-pressure. It must present the next byte before the master's next rising clock edge, because a rising edge that arrives while a byte is still owed is not counted. Raising chip select at any time abandons the transfer, clears a pause and discards the partly sent byte.

Top module: `spi_hold_ctrl`

## Requirements
- R1: While chip select is high, `so_oe` and `hold_o` are 0 and `tx_ready` is 0.
- R2: A low pause pin has no effect while chip select is high: `hold_o` stays 0.
- R3: With chip select low and the serial clock low, driving the pause pin low sets `hold_o` within 4 system clock cycles.
- R4: If the pause pin falls while the serial clock is high, `hold_o` stays 0 until the clock goes low, and is set within 4 cycles after that.
- R5: The pause ends only while the serial clock is low. If the pause pin rises while the clock is high, `hold_o` stays 1 until the clock goes low.
- R6: While `hold_o` is 1, `so_oe` is 0, so the output pin is high impedance.
- R7: Serial clock edges that occur during a pause do not move the bit position. After release, the byte continues unbroken from the same bit, and the following bytes are sent in order.
- R8: Raising chip select during a pause clears `hold_o` and abandons the current byte. The next selection starts with a fresh byte from the stream, sent from its MSB.
- R9: Data leaves MSB first. A bit is advanced only on a falling clock edge that follows a rising edge within the same selection, so clock-idle-low and clock-idle-high timing both deliver the MSB at the first rising edge.
- R10: `tx_ready` is 1 only at a byte boundary while selected and not paused. A byte is taken in a cycle where both `tx_valid` and `tx_ready` are 1. While `tx_valid` is 0, `tx_ready` stays high and no byte is consumed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck_i | input | 1 | Serial clock pin |
| cs_n_i | input | 1 | Chip select pin, active low |
| hold_n_i | input | 1 | Pause pin, active low |
| tx_data | input | DATA_W | Next byte to send |
| tx_valid | input | 1 | `tx_data` holds a byte |
| tx_ready | output | 1 | Block takes a byte this cycle if valid |
| so_o | output | 1 | Serial output data value |
| so_oe | output | 1 | Output enable for the serial data pin |
| hold_o | output | 1 | Pause flag; freezes the slave's shift logic |

## Verification
The bench pauses transfers at several points. It pauses mid-byte while the clock is low, and it toggles the clock during the pause. A design that counted those edges would return a corrupted byte. It also drops and releases the pause pin while the clock is high. A design that acted on the pin edge at once would show the flag early or clear it early. A falling clock edge seen at release would add a spurious shift. Further cases cover chip select rising during a pause, a pause request while deselected, idle-high clock timing where a leading falling edge must not shift, and a stalled byte source.

// File: rtl/spi_hold_pkg.sv
package spi_hold_pkg;
  localparam int PIN_SCK   = 0;
  localparam int PIN_CSN   = 1;
  localparam int PIN_HOLDN = 2;
  localparam int NUM_PINS  = 3;
  // idle pin levels: pause released, deselected, clock low
  localparam logic [NUM_PINS-1:0] PIN_IDLE = 3'b110;
endpackage

// File: rtl/spi_hold_sync.sv
module spi_hold_sync #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] IDLE = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stg[g] <= IDLE;
        else        stg[g] <= d;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stg[g] <= IDLE;
        else        stg[g] <= stg[g-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/spi_hold_fsm.sv
module spi_hold_fsm (
  input  logic clk,
  input  logic rst_n,
  input  logic sck_s,
  input  logic cs_n_s,
  input  logic hold_n_s,
  output logic held
);
  // The pause state follows the pause pin only in the clock-low phase;
  // a change seen while the clock is high waits for the next low phase.
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      held <= 1'b0;
    else if (cs_n_s) held <= 1'b0;
    else if (!sck_s) held <= !hold_n_s;

  p_no_hold_deselected_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_s |=> !held);

  p_enter_clock_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(held) |-> $past(!sck_s && !hold_n_s && !cs_n_s));

  p_exit_clock_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(held) |-> $past(cs_n_s || (!sck_s && hold_n_s)));
endmodule

// File: rtl/spi_hold_shift.sv
module spi_hold_shift #(
  parameter int DATA_W = 8,
  localparam int CW = (DATA_W > 1) ? $clog2(DATA_W) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck_s,
  input  logic              sel,
  input  logic              held,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  output logic              so_bit
);
  localparam logic [CW-1:0] LAST = CW'(DATA_W - 1);

  logic              sck_q;
  logic [DATA_W-1:0] sh;
  logic [CW-1:0]     cnt;
  logic              need;
  logic              armed;
  logic              live;
  logic              rise;
  logic              fall;

  assign live     = sel && !held;
  assign rise     = live && sck_s && !sck_q;
  assign fall     = live && !sck_s && sck_q;
  assign tx_ready = live && need;
  assign so_bit   = sh[DATA_W-1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sck_q <= 1'b0;
    else        sck_q <= sck_s;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sh    <= '0;
      cnt   <= '0;
      need  <= 1'b1;
      armed <= 1'b0;
    end else if (!sel) begin
      cnt   <= '0;
      need  <= 1'b1;
      armed <= 1'b0;
    end else if (!held) begin
      if (need) begin
        if (tx_valid) begin
          sh    <= tx_data;
          need  <= 1'b0;
          armed <= 1'b0;
          cnt   <= '0;
        end
      end else begin
        if (rise) armed <= 1'b1;
        if (fall && armed) begin
          armed <= 1'b0;
          if (cnt == LAST) begin
            need <= 1'b1;
            cnt  <= '0;
          end else begin
            sh  <= sh << 1;
            cnt <= cnt + 1'b1;
          end
        end
      end
    end

  p_freeze_while_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (held && sel) |=> ($stable(cnt) && $stable(sh) && $stable(armed)));

  p_ready_at_boundary_r10: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> (cnt == '0 && !armed));
endmodule

// File: rtl/spi_hold_ctrl.sv
module spi_hold_ctrl #(
  parameter int DATA_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck_i,
  input  logic              cs_n_i,
  input  logic              hold_n_i,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  output logic              so_o,
  output logic              so_oe,
  output logic              hold_o
);
  import spi_hold_pkg::*;

  logic [NUM_PINS-1:0] pins_raw;
  logic [NUM_PINS-1:0] pins_s;
  logic                held;
  logic                sel;

  assign pins_raw[PIN_SCK]   = sck_i;
  assign pins_raw[PIN_CSN]   = cs_n_i;
  assign pins_raw[PIN_HOLDN] = hold_n_i;

  spi_hold_sync #(.W(NUM_PINS), .STAGES(SYNC_STAGES), .IDLE(PIN_IDLE)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pins_raw), .q(pins_s)
  );

  spi_hold_fsm u_fsm (
    .clk(clk), .rst_n(rst_n),
    .sck_s(pins_s[PIN_SCK]), .cs_n_s(pins_s[PIN_CSN]), .hold_n_s(pins_s[PIN_HOLDN]),
    .held(held)
  );

  assign sel = !pins_s[PIN_CSN];

  spi_hold_shift #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .sck_s(pins_s[PIN_SCK]), .sel(sel), .held(held),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready), .so_bit(so_o)
  );

  assign so_oe  = sel && !held;
  assign hold_o = held;
endmodule

// File: tb/sim_spi_hold_ctrl.sv
module sim_spi_hold_ctrl;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0, cs_n = 1'b1, hold_n = 1'b1, src_en = 1'b1;
  int   idx = 0;
  int   nchk = 0, nfail = 0;
  logic [7:0] tx_data;
  logic tx_ready, so_o, so_oe, hold_o;
  wire  so_pin = so_oe ? so_o : 1'bz;

  always #5 clk = ~clk;

  function automatic logic [7:0] pat(int i);
    return 8'hA5 ^ 8'(i * 37);
  endfunction

  assign tx_data = pat(idx);

  always @(posedge clk) if (src_en && tx_ready) idx <= idx + 1;

  spi_hold_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .sck_i(sck), .cs_n_i(cs_n), .hold_n_i(hold_n),
    .tx_data(tx_data), .tx_valid(src_en), .tx_ready(tx_ready),
    .so_o(so_o), .so_oe(so_oe), .hold_o(hold_o)
  );

  task automatic hc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bit_m0(inout logic [7:0] b);
    hc(HALF); b = {b[6:0], so_pin}; sck = 1'b1; hc(HALF); sck = 1'b0;
  endtask

  task automatic bits_m0(int n, inout logic [7:0] b);
    for (int i = 0; i < n; i++) bit_m0(b);
  endtask

  task automatic t_reset;
    chk("R1 so_oe", so_oe, 0);
    chk("R1 hold", hold_o, 0);
    chk("R1 ready", tx_ready, 0);
    chk("R1 pin z", so_pin, 1'bz);
  endtask

  task automatic t_plain_m0;
    logic [7:0] b; int e;
    e = idx; cs_n = 1'b0;
    bits_m0(8, b); chk("R9 byte0 mode0", b, pat(e));
    bits_m0(8, b); chk("R10 byte1 in order", b, pat(e + 1));
    cs_n = 1'b1; hc(6);
  endtask

  task automatic t_mode3;
    logic [7:0] b; int e;
    sck = 1'b1; hc(6);
    e = idx; cs_n = 1'b0; hc(HALF);
    for (int i = 0; i < 8; i++) begin
      sck = 1'b0; hc(HALF); b = {b[6:0], so_pin}; sck = 1'b1; hc(HALF);
    end
    chk("R9 byte mode3", b, pat(e));
    cs_n = 1'b1; hc(6); sck = 1'b0; hc(6);
  endtask

  task automatic t_hold_mid;
    logic [7:0] b; int e;
    e = idx; cs_n = 1'b0;
    bits_m0(3, b);
    hold_n = 1'b0; hc(6);
    chk("R3 hold set", hold_o, 1);
    chk("R6 pin z", so_pin, 1'bz);
    for (int i = 0; i < 2; i++) begin
      sck = 1'b1; hc(HALF); sck = 1'b0; hc(HALF);
    end
    chk("R7 still held", hold_o, 1);
    hold_n = 1'b1; hc(6);
    chk("R5 released", hold_o, 0);
    chk("R6 driven", so_oe, 1);
    bits_m0(5, b); chk("R7 byte unbroken", b, pat(e));
    bits_m0(8, b); chk("R7 next byte", b, pat(e + 1));
    cs_n = 1'b1; hc(6);
  endtask

  task automatic t_hold_deferred;
    logic [7:0] b; int e;
    e = idx; cs_n = 1'b0;
    bits_m0(2, b);
    hc(HALF); b = {b[6:0], so_pin}; sck = 1'b1; hc(HALF);
    hold_n = 1'b0; hc(8);
    chk("R4 deferred entry", hold_o, 0);
    sck = 1'b0; hc(6);
    chk("R4 entry at low", hold_o, 1);
    sck = 1'b1; hc(HALF);
    hold_n = 1'b1; hc(8);
    chk("R5 deferred exit", hold_o, 1);
    sck = 1'b0; hc(6);
    chk("R5 exit at low", hold_o, 0);
    bits_m0(5, b); chk("R7 byte after deferred", b, pat(e));
    cs_n = 1'b1; hc(6);
  endtask

  task automatic t_cs_abort;
    logic [7:0] b; int e;
    cs_n = 1'b0;
    bits_m0(4, b);
    hold_n = 1'b0; hc(6);
    chk("R3 held before abort", hold_o, 1);
    cs_n = 1'b1; hc(6);
    chk("R8 hold cleared", hold_o, 0);
    chk("R1 pin z after abort", so_pin, 1'bz);
    hc(10);
    chk("R2 no hold deselected", hold_o, 0);
    hold_n = 1'b1; hc(4);
    e = idx; cs_n = 1'b0;
    bits_m0(8, b); chk("R8 fresh byte", b, pat(e));
    cs_n = 1'b1; hc(6);
  endtask

  task automatic t_backpressure;
    logic [7:0] b; int e;
    src_en = 1'b0; e = idx; cs_n = 1'b0; hc(10);
    chk("R10 ready while waiting", tx_ready, 1);
    chk("R10 nothing taken", idx, e);
    src_en = 1'b1; hc(2);
    chk("R10 ready drops after take", tx_ready, 0);
    bits_m0(8, b); chk("R10 byte after stall", b, pat(e));
    cs_n = 1'b1; hc(6);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    hc(4); rst_n = 1'b1; hc(6);
    t_reset;
    t_plain_m0;
    t_mode3;
    t_hold_mid;
    t_hold_deferred;
    t_cs_abort;
    t_backpressure;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule